// File: doc/BRIEF.md
# BCD Hour Counter with 12/24-Hour Format

This block holds the hour of a real-time clock as packed BCD and advances it once for each one-cycle hour-carry pulse from a minutes counter. A mode input selects either a 24-hour count or a 12-hour count with a PM flag. In 12-hour format the PM flag is bit 5 of the byte on top of the BCD hour. Noon therefore reads 32h and midnight reads 12h.

Software loads the time through a parallel write port with a strobe. The mode should be set before the time is loaded, because a change of mode does not reformat the stored byte. When the count wraps at the end of the day, a one-cycle day pulse goes out to a following day counter.

Top module: `bcd_hour_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the hour is set to 12h if `fmt24` is 0, or to 00h if `fmt24` is 1, and `day_tick` is set to 0.
- R2: On a cycle with neither `hr_tick` nor `wr_en`, the hour does not change, and `day_tick` is 0 in the following cycle.
- R3: With `fmt24`=1, each `hr_tick` advances the hour one step through 00h, 01h .. 09h, 10h .. 19h, 20h .. 23h, and then back to 00h.
- R4: With `fmt24`=0, each `hr_tick` advances the hour through 12h, 01h .. 11h, 32h, 21h .. 31h, and then back to 12h. Bit 5 is the PM flag and the low five bits are the BCD hour 1..12.
- R5: `day_tick` is high for exactly one cycle. That cycle is the one in which the hour first shows the value after a tick-driven step from 23h (with `fmt24`=1) or from 31h (with `fmt24`=0). It is 0 at all other times.
- R6: `wr_en` loads `wr_data[5:0]` into the hour on the next edge and takes priority over a coincident `hr_tick`. `wr_data[7:6]` is ignored, and `hour_q[7:6]` always reads 0.
- R7: Changing `fmt24` leaves the stored hour unchanged. Only the next step follows the new format.
- R8: A stored value outside the legal set advances to the next legal hour, without a `day_tick`. Take the tens digit as bits 5:4 (24-hour) or bit 4 (12-hour), and cap a units digit above 9 at 9. In 24-hour format, a value at 23 or above goes to 00h. In 12-hour format, 00h or 20h counts as 12 o'clock of that half, and 13..19 counts as 11 of that half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hr_tick | input | 1 | One-cycle hour carry from the minutes counter |
| fmt24 | input | 1 | Format select: 0 = 12-hour with PM flag, 1 = 24-hour |
| wr_en | input | 1 | Load strobe for the hour |
| wr_data | input | 8 | Hour value to load |
| hour_q | output | 8 | Current hour, packed BCD |
| day_tick | output | 1 | One-cycle pulse at the end-of-day wrap |

## Verification
A whole day of 24 ticks is run in each format from reset, and every value is compared with a sequence computed from the tick index. This separates the BCD carry at x9, the noon and midnight jumps, and the single correct wrap point for `day_tick`. All 64 low-bit patterns are then loaded in both formats, with junk in the high bits, and stepped once. This exercises load masking, the out-of-range recovery rule, and the absence of spurious day pulses. Idle cycles, a write that coincides with a tick, and a format flip on a stored value show that holding, write priority and the no-reformat rule behave correctly.

// File: rtl/bcd_hour_counter.sv
module bcd_hour_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       hr_tick,
  input  logic       fmt24,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] hour_q,
  output logic       day_tick
);

  logic [5:0] hr, nxt;
  logic       wrap;

  wire [1:0] tens = hr[5:4];
  wire [3:0] ones = hr[3:0];
  wire       pm   = hr[5];

  always_comb begin
    nxt  = hr + 6'd1;
    wrap = 1'b0;
    if (fmt24) begin
      if (tens == 2'd3 || (tens == 2'd2 && ones >= 4'd3)) begin
        nxt  = 6'h00;
        wrap = (hr == 6'h23);
      end else if (ones >= 4'd9) begin
        nxt = {tens + 2'd1, 4'd0};
      end
    end else begin
      if (hr[4] && ones == 4'd2) begin
        nxt = {pm, 5'h01};
      end else if (hr[4] && ones != 4'd0) begin
        nxt  = pm ? 6'h12 : 6'h32;
        wrap = (hr == 6'h31);
      end else if (!hr[4] && ones >= 4'd9) begin
        nxt = {pm, 5'h10};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr       <= fmt24 ? 6'h00 : 6'h12;
      day_tick <= 1'b0;
    end else begin
      day_tick <= 1'b0;
      if (wr_en) begin
        hr <= wr_data[5:0];
      end else if (hr_tick) begin
        hr       <= nxt;
        day_tick <= wrap;
      end
    end
  end

  assign hour_q = {2'b00, hr};

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hr_tick && !wr_en) |=> ($stable(hour_q) && !day_tick));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (hour_q == {2'b00, $past(wr_data[5:0])}));

  // R5
  wrap12_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_tick && !wr_en && !fmt24 && hour_q == 8'h31) |=> (day_tick && hour_q == 8'h12));

  // R5
  wrap24_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_tick && !wr_en && fmt24 && hour_q == 8'h23) |=> (day_tick && hour_q == 8'h00));

  // R5
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    day_tick |-> $past(hr_tick && !wr_en));

  // R3
  legal24_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_tick && !wr_en && fmt24) |=> (hour_q[3:0] <= 4'd9 && hour_q <= 8'h23));

endmodule

// File: tb/tb_bcd_hour_counter.sv
module tb_bcd_hour_counter;
  logic clk = 1'b0;
  logic rst = 1'b1, hr_tick = 1'b0, fmt24 = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] hour_q;
  logic day_tick;
  int checks = 0, errors = 0;

  bcd_hour_counter dut (.clk(clk), .rst(rst), .hr_tick(hr_tick), .fmt24(fmt24),
    .wr_en(wr_en), .wr_data(wr_data), .hour_q(hour_q), .day_tick(day_tick));

  always #4 clk = ~clk;

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] enc24(int i);
    return 8'((i / 10) * 16 + i % 10);
  endfunction

  function automatic logic [7:0] enc12(int i);
    int h = (i % 12 == 0) ? 12 : i % 12;
    return 8'((i >= 12 ? 32 : 0) + (h / 10) * 16 + h % 10);
  endfunction

  function automatic logic [7:0] next_of(logic [5:0] v, logic m24);
    int o = (v[3:0] > 9) ? 9 : int'(v[3:0]);
    if (m24) begin
      int b = int'(v[5:4]) * 10 + o;
      return (b >= 23) ? 8'h00 : enc24(b + 1);
    end else begin
      int h = int'(v[4]) * 10 + o;
      int r = (h == 0 || h == 12) ? 0 : (h > 11 ? 11 : h);
      int idx = int'(v[5]) * 12 + r;
      return enc12((idx + 1) % 24);
    end
  endfunction

  task automatic chk(string req, logic [7:0] exp_h, logic exp_t);
    checks++;
    if (hour_q !== exp_h || day_tick !== exp_t) begin
      errors++;
      $display("FAIL %s hour=%h tick=%b expected hour=%h tick=%b", req, hour_q, day_tick, exp_h, exp_t);
    end
  endtask

  task automatic step(logic t, logic w, logic [7:0] d);
    @(negedge clk);
    hr_tick = t; wr_en = w; wr_data = d;
    @(posedge clk); #1;
    hr_tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    // R1 reset in 12-hour format
    fmt24 = 1'b0; rst = 1'b1;
    step(0, 0, 8'h00); step(0, 0, 8'h00);
    chk("R1", 8'h12, 1'b0);
    rst = 1'b0;

    // R4 full day in 12-hour format, R5 wrap pulse
    for (int i = 1; i <= 24; i++) begin
      step(1, 0, 8'h00);
      chk(i == 24 ? "R5" : "R4", enc12(i % 24), i == 24);
    end
    // R2 hold with idle cycles
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 8'h00);
      chk("R2", 8'h12, 1'b0);
    end

    // R1 reset in 24-hour format
    @(negedge clk); fmt24 = 1'b1; rst = 1'b1;
    step(0, 0, 8'h00);
    chk("R1", 8'h00, 1'b0);
    rst = 1'b0;

    // R3 full day in 24-hour format, R5 wrap pulse
    for (int i = 1; i <= 24; i++) begin
      step(1, 0, 8'h00);
      chk(i == 24 ? "R5" : "R3", enc24(i % 24), i == 24);
    end

    // R6 write beats tick, high bits masked
    step(1, 1, 8'hD7);
    chk("R6", 8'h17, 1'b0);
    step(0, 0, 8'h00);
    chk("R2", 8'h17, 1'b0);

    // R7 format flip keeps value, next step follows new format
    @(negedge clk); fmt24 = 1'b0;
    step(0, 0, 8'h00);
    chk("R7", 8'h17, 1'b0);
    step(1, 0, 8'h00);
    chk("R7", 8'h32, 1'b0);

    // R6 R8 sweep of all loadable values in both formats
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); fmt24 = m[0];
      for (int v = 0; v < 64; v++) begin
        logic [5:0] lv = 6'(v);
        logic wr = (m == 1) ? (lv == 6'h23) : (lv == 6'h31);
        step(0, 1, {lv[1:0], lv});
        chk("R6", {2'b00, lv}, 1'b0);
        step(1, 0, 8'h00);
        chk(wr ? "R5" : "R8", next_of(lv, m[0]), wr);
        step(0, 0, 8'h00);
        chk("R5", next_of(lv, m[0]), 1'b0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule